// File: doc/BRIEF.md
# Block Command Descriptor Decoder

This block watches a stream of command bytes as a storage target receives them and turns a 10-byte read or write command into a ready-to-use block request. For each command it gives the operation class, the transfer direction, the starting block address, the block count and the total byte count. A small set of flags goes with the request: an unsupported opcode, an absent target, and the length of the command buffer.

A device-type input chooses between a disk with 512-byte sectors and an optical drive with 2048-byte sectors. For the optical type, the address and the count are converted to 512-byte units, and the byte count uses the larger sector. The block also drives the sector-size byte that a capacity reply carries. Commands can arrive in two ways. In a DMA transfer, the first byte is an identify message. In a programmed-I/O transfer there is no such byte, so the block inserts a zero in its place. In both cases every field sits at the same buffer position.

Top module: `cdb_decoder`

## Requirements
- R1: A byte with `cmd_start` high opens a new command. With `pio_mode` low, that byte is buffer index 0, the identify byte. With `pio_mode` high, that byte is buffer index 1 and index 0 counts as zero. Every later byte takes the next index.
- R2: `req_valid` goes high for exactly one cycle, in the cycle after the clock edge that accepts a byte with both `byte_valid` and `cmd_last` high. It stays low at all other times.
- R3: The opcode is buffer index 1. 0x28 gives `op_class` 1 (read) with `xfer_dir` 1 (device to host). 0x2A gives `op_class` 2 (write) with `xfer_dir` 0. 0x25 gives `op_class` 3 (capacity) with `xfer_dir` 1. Any other value gives `op_class` 0 (unsupported) with `xfer_dir` 0.
- R4: For read and write, the raw block address is buffer indices 3 to 6, most significant byte first. The raw block count is indices 8 and 9, most significant byte first.
- R5: With `dev_optical` low, `blk_addr` and `blk_count` carry the raw address and count unchanged, and `byte_count` is the count times 512.
- R6: With `dev_optical` high, `blk_addr` and `blk_count` are the raw values times four, and `byte_count` is the raw count times 2048.
- R7: An unsupported opcode gives zero for address, count and byte count. A capacity opcode gives zero for address and count, and 8 for the byte count.
- R8: `cap_sector_byte` is 8 while `dev_optical` is high and 2 while it is low. It follows the input without a clock.
- R9: `no_device` is 1 when the `target_id` present with the last byte is above 4, and 0 otherwise.
- R10: `cmd_len` is the number of buffer bytes, counting the inserted zero in PIO mode. It saturates at 31.
- R11: Buffer positions that a command never reaches read as zero. Bytes past index 9 have no effect. A command may start in the cycle right after the previous last byte without changing the result that is shown in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A command byte is present this cycle |
| byte_data | input | 8 | Command byte |
| cmd_start | input | 1 | This byte is the first of a command |
| cmd_last | input | 1 | This byte is the last of a command |
| pio_mode | input | 1 | 1: bytes came by programmed I/O (identify byte implied) |
| dev_optical | input | 1 | 1: 2048-byte-sector optical device, 0: 512-byte disk |
| target_id | input | 3 | Selected target number |
| req_valid | output | 1 | Decoded request valid (one-cycle pulse) |
| op_class | output | 2 | 0 unsupported, 1 read, 2 write, 3 capacity |
| xfer_dir | output | 1 | 1 device to host, 0 host to device |
| blk_addr | output | 34 | Block address in 512-byte units |
| blk_count | output | 18 | Block count in 512-byte units |
| byte_count | output | 27 | Total bytes to move |
| unsupported | output | 1 | Opcode not recognised |
| no_device | output | 1 | Target number out of range |
| cmd_len | output | 5 | Command buffer length, saturating |
| cap_sector_byte | output | 8 | Sector-size byte for the capacity reply |

## Verification
Two things can happen in the same cycle. The result of one command is on the outputs while the first byte of the next command is being accepted, and that byte clears the stored fields. The bench sends commands back to back with no idle cycle between them, including a one-byte command, and changes the mode and device inputs at each command boundary. A scoreboard matches each result against its expected entry and checks the exact cycle in which it appears. Any corruption from the overlapping start therefore shows up as a wrong field or a wrong cycle.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
   typedef enum logic [1:0] {
      OPC_UNSUP    = 2'd0,
      OPC_READ     = 2'd1,
      OPC_WRITE    = 2'd2,
      OPC_CAPACITY = 2'd3
   } opc_class_e;

   localparam logic [7:0] OPC_READ10  = 8'h28;
   localparam logic [7:0] OPC_WRITE10 = 8'h2A;
   localparam logic [7:0] OPC_RDCAP   = 8'h25;

   localparam int CAP_RESP_BYTES = 8;
   localparam int OPCODE_SLOT    = 1;
   localparam int LBA_FIRST_SLOT = 3;
endpackage

// File: rtl/cdb_slot.sv
module cdb_slot #(
   parameter int IDX_W = 5,
   parameter int SLOT  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid,
   input  logic             cmd_start,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic [7:0]       byte_data,
   output logic [7:0]       nxt
);
   logic [7:0] held_q;

   // Value this slot holds once the current byte is taken in.
   always_comb begin
      if (cur_idx == IDX_W'(SLOT))
         nxt = byte_data;
      else if (cmd_start)
         nxt = '0;
      else
         nxt = held_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= '0;
      else if (byte_valid)
         held_q <= nxt;
   end
endmodule

// File: rtl/cdb_collector.sv
module cdb_collector
   import cdb_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter int LBA_BYTES = 4,
   parameter int CNT_BYTES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   byte_valid,
   input  logic [7:0]             byte_data,
   input  logic                   cmd_start,
   input  logic                   pio_mode,
   output logic [7:0]             nxt_opcode,
   output logic [LBA_BYTES*8-1:0] nxt_lba,
   output logic [CNT_BYTES*8-1:0] nxt_cnt,
   output logic [IDX_W-1:0]       nxt_len
);
   localparam int LBA_W     = LBA_BYTES * 8;
   localparam int CNT_W     = CNT_BYTES * 8;
   localparam int CNT_FIRST = LBA_FIRST_SLOT + LBA_BYTES + 1;
   localparam logic [IDX_W-1:0] POS_MAX = '1;

   logic [IDX_W-1:0] pos_q;
   logic [IDX_W-1:0] cur_idx;

   // A programmed-I/O command starts at index 1; index 0 is an implied zero.
   always_comb begin
      if (cmd_start)
         cur_idx = pio_mode ? IDX_W'(1) : '0;
      else
         cur_idx = pos_q;
      nxt_len = (cur_idx == POS_MAX) ? POS_MAX : cur_idx + IDX_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (byte_valid)
         pos_q <= (cur_idx == POS_MAX) ? POS_MAX : cur_idx + IDX_W'(1);
   end

   cdb_slot #(.IDX_W(IDX_W), .SLOT(OPCODE_SLOT)) u_opc (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .cmd_start(cmd_start),
      .cur_idx(cur_idx), .byte_data(byte_data), .nxt(nxt_opcode)
   );

   for (genvar g = 0; g < LBA_BYTES; g++) begin : g_lba
      cdb_slot #(.IDX_W(IDX_W), .SLOT(LBA_FIRST_SLOT + g)) u_slot (
         .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .cmd_start(cmd_start),
         .cur_idx(cur_idx), .byte_data(byte_data), .nxt(nxt_lba[LBA_W-1-8*g -: 8])
      );
   end

   for (genvar g = 0; g < CNT_BYTES; g++) begin : g_cnt
      cdb_slot #(.IDX_W(IDX_W), .SLOT(CNT_FIRST + g)) u_slot (
         .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .cmd_start(cmd_start),
         .cur_idx(cur_idx), .byte_data(byte_data), .nxt(nxt_cnt[CNT_W-1-8*g -: 8])
      );
   end
endmodule

// File: rtl/cdb_decode.sv
module cdb_decode
   import cdb_pkg::*;
#(
   parameter int LBA_W     = 32,
   parameter int CNT_W     = 16,
   parameter int OPT_SHIFT = 2,
   parameter int SECT_LOG2 = 9
) (
   input  logic [7:0]                         opcode,
   input  logic [LBA_W-1:0]                   lba_raw,
   input  logic [CNT_W-1:0]                   cnt_raw,
   input  logic                               optical,
   output opc_class_e                         cls,
   output logic                               dir,
   output logic [LBA_W+OPT_SHIFT-1:0]         lba_s,
   output logic [CNT_W+OPT_SHIFT-1:0]         cnt_s,
   output logic [CNT_W+OPT_SHIFT+SECT_LOG2-1:0] bytes
);
   localparam int AO_W = LBA_W + OPT_SHIFT;
   localparam int CO_W = CNT_W + OPT_SHIFT;
   localparam int BC_W = CO_W + SECT_LOG2;

   logic [AO_W-1:0] lba_sc;
   logic [CO_W-1:0] cnt_sc;

   if (OPT_SHIFT == 0) begin : g_noscale
      assign lba_sc = lba_raw;
      assign cnt_sc = cnt_raw;
   end else begin : g_scale
      assign lba_sc = optical ? {lba_raw, {OPT_SHIFT{1'b0}}} : {{OPT_SHIFT{1'b0}}, lba_raw};
      assign cnt_sc = optical ? {cnt_raw, {OPT_SHIFT{1'b0}}} : {{OPT_SHIFT{1'b0}}, cnt_raw};
   end

   always_comb begin
      cls   = OPC_UNSUP;
      dir   = 1'b0;
      lba_s = '0;
      cnt_s = '0;
      bytes = '0;
      case (opcode)
         OPC_READ10: begin
            cls   = OPC_READ;
            dir   = 1'b1;
            lba_s = lba_sc;
            cnt_s = cnt_sc;
            bytes = {cnt_sc, {SECT_LOG2{1'b0}}};
         end
         OPC_WRITE10: begin
            cls   = OPC_WRITE;
            lba_s = lba_sc;
            cnt_s = cnt_sc;
            bytes = {cnt_sc, {SECT_LOG2{1'b0}}};
         end
         OPC_RDCAP: begin
            cls   = OPC_CAPACITY;
            dir   = 1'b1;
            bytes = BC_W'(CAP_RESP_BYTES);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cdb_decoder.sv
module cdb_decoder
   import cdb_pkg::*;
#(
   parameter int LBA_BYTES  = 4,
   parameter int CNT_BYTES  = 2,
   parameter int IDX_W      = 5,
   parameter int SECT_LOG2  = 9,
   parameter int OPT_SHIFT  = 2,
   parameter int TGT_W      = 3,
   parameter int MAX_TARGET = 4
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           byte_valid,
   input  logic [7:0]                                     byte_data,
   input  logic                                           cmd_start,
   input  logic                                           cmd_last,
   input  logic                                           pio_mode,
   input  logic                                           dev_optical,
   input  logic [TGT_W-1:0]                               target_id,
   output logic                                           req_valid,
   output logic [1:0]                                     op_class,
   output logic                                           xfer_dir,
   output logic [LBA_BYTES*8+OPT_SHIFT-1:0]               blk_addr,
   output logic [CNT_BYTES*8+OPT_SHIFT-1:0]               blk_count,
   output logic [CNT_BYTES*8+OPT_SHIFT+SECT_LOG2-1:0]     byte_count,
   output logic                                           unsupported,
   output logic                                           no_device,
   output logic [IDX_W-1:0]                               cmd_len,
   output logic [7:0]                                     cap_sector_byte
);
   localparam int LBA_W     = LBA_BYTES * 8;
   localparam int CNT_W     = CNT_BYTES * 8;
   localparam int AO_W      = LBA_W + OPT_SHIFT;
   localparam int CO_W      = CNT_W + OPT_SHIFT;
   localparam int BC_W      = CO_W + SECT_LOG2;
   localparam int LAST_SLOT = LBA_FIRST_SLOT + LBA_BYTES + CNT_BYTES;
   localparam logic [7:0] CAP_DISK = 8'((1 << SECT_LOG2) >> 8);
   localparam logic [7:0] CAP_OPT  = 8'((1 << (SECT_LOG2 + OPT_SHIFT)) >> 8);

   if (LAST_SLOT >= (1 << IDX_W) - 1) begin : g_bad_idx
      $error("IDX_W too narrow for the command layout");
   end
   if (SECT_LOG2 + OPT_SHIFT < 8 || SECT_LOG2 + OPT_SHIFT > 15) begin : g_bad_sect
      $error("sector sizes must fit the capacity byte");
   end
   if (MAX_TARGET >= (1 << TGT_W)) begin : g_bad_tgt
      $error("MAX_TARGET exceeds target_id range");
   end

   logic [7:0]       c_opcode;
   logic [LBA_W-1:0] c_lba;
   logic [CNT_W-1:0] c_cnt;
   logic [IDX_W-1:0] c_len;

   cdb_collector #(.IDX_W(IDX_W), .LBA_BYTES(LBA_BYTES), .CNT_BYTES(CNT_BYTES)) u_coll (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .cmd_start(cmd_start), .pio_mode(pio_mode),
      .nxt_opcode(c_opcode), .nxt_lba(c_lba), .nxt_cnt(c_cnt), .nxt_len(c_len)
   );

   opc_class_e       d_cls;
   logic             d_dir;
   logic [AO_W-1:0]  d_lba;
   logic [CO_W-1:0]  d_cnt;
   logic [BC_W-1:0]  d_bytes;

   cdb_decode #(.LBA_W(LBA_W), .CNT_W(CNT_W), .OPT_SHIFT(OPT_SHIFT), .SECT_LOG2(SECT_LOG2)) u_dec (
      .opcode(c_opcode), .lba_raw(c_lba), .cnt_raw(c_cnt), .optical(dev_optical),
      .cls(d_cls), .dir(d_dir), .lba_s(d_lba), .cnt_s(d_cnt), .bytes(d_bytes)
   );

   // The request is latched on the edge that takes in the final byte.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid   <= 1'b0;
         op_class    <= '0;
         xfer_dir    <= 1'b0;
         blk_addr    <= '0;
         blk_count   <= '0;
         byte_count  <= '0;
         unsupported <= 1'b0;
         no_device   <= 1'b0;
         cmd_len     <= '0;
      end else begin
         req_valid <= byte_valid && cmd_last;
         if (byte_valid && cmd_last) begin
            op_class    <= d_cls;
            xfer_dir    <= d_dir;
            blk_addr    <= d_lba;
            blk_count   <= d_cnt;
            byte_count  <= d_bytes;
            unsupported <= (d_cls == OPC_UNSUP);
            no_device   <= (target_id > TGT_W'(MAX_TARGET));
            cmd_len     <= c_len;
         end
      end
   end

   assign cap_sector_byte = dev_optical ? CAP_OPT : CAP_DISK;

   p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(byte_valid && cmd_last));

   p_write_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op_class == 2'(OPC_WRITE)) |-> !xfer_dir);

   p_read_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op_class == 2'(OPC_READ)) |-> xfer_dir);

   p_unsup_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && unsupported) |-> (blk_addr == '0 && blk_count == '0 && byte_count == '0));

   p_nodev_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (no_device == ($past(target_id) > TGT_W'(MAX_TARGET))));

   if (OPT_SHIFT > 0) begin : g_scale_chk
      p_opt_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && $past(dev_optical)) |->
            (blk_addr[OPT_SHIFT-1:0] == '0 && blk_count[OPT_SHIFT-1:0] == '0));

      p_disk_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !$past(dev_optical)) |->
            (blk_count[CO_W-1:CNT_W] == '0 && blk_addr[AO_W-1:LBA_W] == '0));
   end
endmodule

// File: tb/tb_cdb_decoder.sv
module tb_cdb_decoder;
   import cdb_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        byte_valid, cmd_start, cmd_last, pio_mode, dev_optical;
   logic [7:0]  byte_data;
   logic [2:0]  target_id;
   logic        req_valid, xfer_dir, unsupported, no_device;
   logic [1:0]  op_class;
   logic [33:0] blk_addr;
   logic [17:0] blk_count;
   logic [26:0] byte_count;
   logic [4:0]  cmd_len;
   logic [7:0]  cap_sector_byte;

   always #2 clk = ~clk;

   cdb_decoder dut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .cmd_start(cmd_start), .cmd_last(cmd_last), .pio_mode(pio_mode),
      .dev_optical(dev_optical), .target_id(target_id),
      .req_valid(req_valid), .op_class(op_class), .xfer_dir(xfer_dir),
      .blk_addr(blk_addr), .blk_count(blk_count), .byte_count(byte_count),
      .unsupported(unsupported), .no_device(no_device), .cmd_len(cmd_len),
      .cap_sector_byte(cap_sector_byte)
   );

   typedef struct {
      logic [1:0]  cls;
      logic        dir;
      logic [33:0] lba;
      logic [17:0] cnt;
      logic [26:0] bytes;
      logic        nodev;
      logic [4:0]  len;
      logic        opt;
      int          due;
   } exp_t;

   exp_t        exp_q[$];
   exp_t        got;
   logic [7:0]  cb[$];
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Monitor: compare each produced request with the scoreboard head.
   always @(negedge clk) begin
      if (rst_n && req_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected req_valid", 64'd1, 64'd0);
         end else begin
            got = exp_q.pop_front();
            chk(cyc == got.due, "R2 result cycle", 64'(cyc), 64'(got.due));
            chk(op_class == got.cls, "R3 op_class", 64'(op_class), 64'(got.cls));
            chk(xfer_dir == got.dir, "R3 xfer_dir", 64'(xfer_dir), 64'(got.dir));
            chk(unsupported == (got.cls == 2'd0), "R7 unsupported flag", 64'(unsupported), 64'(got.cls == 2'd0));
            chk(blk_addr == got.lba, got.opt ? "R6 blk_addr" : "R5 blk_addr", 64'(blk_addr), 64'(got.lba));
            chk(blk_count == got.cnt, got.opt ? "R6 blk_count" : "R5 blk_count", 64'(blk_count), 64'(got.cnt));
            chk(byte_count == got.bytes, got.opt ? "R6 byte_count" : "R5 byte_count", 64'(byte_count), 64'(got.bytes));
            chk(no_device == got.nodev, "R9 no_device", 64'(no_device), 64'(got.nodev));
            chk(cmd_len == got.len, "R10 cmd_len", 64'(cmd_len), 64'(got.len));
         end
      end
   end

   // Driver: compute the expected request from cb, then send the bytes.
   task automatic run_cmd(input bit pio, input bit opt, input logic [2:0] tgt);
      logic [7:0] b [0:9];
      logic [7:0] bq[$];
      logic [31:0] lraw;
      logic [15:0] craw;
      exp_t e;
      bit rw;
      bq = {};
      if (pio) bq.push_back(8'h00);   // R1: implied identify byte
      foreach (cb[i]) bq.push_back(cb[i]);
      for (int i = 0; i < 10; i++) b[i] = (i < bq.size()) ? bq[i] : 8'h00;
      lraw = {b[3], b[4], b[5], b[6]};   // R4
      craw = {b[8], b[9]};
      case (b[1])
         8'h28:   begin e.cls = 2'd1; e.dir = 1'b1; end
         8'h2A:   begin e.cls = 2'd2; e.dir = 1'b0; end
         8'h25:   begin e.cls = 2'd3; e.dir = 1'b1; end
         default: begin e.cls = 2'd0; e.dir = 1'b0; end
      endcase
      rw = (e.cls == 2'd1) || (e.cls == 2'd2);
      e.lba   = rw ? (opt ? {lraw, 2'b00} : {2'b00, lraw}) : 34'd0;
      e.cnt   = rw ? (opt ? {craw, 2'b00} : {2'b00, craw}) : 18'd0;
      e.bytes = rw ? 27'(craw) * 27'(opt ? 2048 : 512) : ((e.cls == 2'd3) ? 27'd8 : 27'd0);
      e.nodev = (tgt > 3'd4);
      e.len   = (bq.size() > 31) ? 5'd31 : 5'(bq.size());
      e.opt   = opt;
      pio_mode    = pio;
      dev_optical = opt;
      target_id   = tgt;
      for (int i = 0; i < cb.size(); i++) begin
         byte_valid = 1'b1;
         byte_data  = cb[i];
         cmd_start  = (i == 0);
         cmd_last   = (i == cb.size() - 1);
         if (i == cb.size() - 1) begin
            e.due = cyc + 1;
            exp_q.push_back(e);
         end
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      byte_valid = 1'b0;
      cmd_start  = 1'b0;
      cmd_last   = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; byte_valid = 1'b0; byte_data = '0; cmd_start = 1'b0; cmd_last = 1'b0;
      pio_mode = 1'b0; dev_optical = 1'b0; target_id = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_valid == 1'b0, "R2 reset req_valid", 64'(req_valid), 64'd0);
      chk(op_class == 2'd0 && blk_addr == '0, "R2 reset outputs", 64'(blk_addr), 64'd0);
      chk(cmd_len == 5'd0, "R10 reset cmd_len", 64'(cmd_len), 64'd0);

      // R8: capacity sector byte follows the device type
      dev_optical = 1'b0; #1;
      chk(cap_sector_byte == 8'd2, "R8 disk sector byte", 64'(cap_sector_byte), 64'd2);
      dev_optical = 1'b1; #1;
      chk(cap_sector_byte == 8'd8, "R8 optical sector byte", 64'(cap_sector_byte), 64'd8);
      @(negedge clk);

      // R1 R4 R5: DMA disk read
      cb = '{8'h00, 8'h28, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h00, 8'h10};
      run_cmd(1'b0, 1'b0, 3'd0); idle(3);
      // R1 R6: PIO optical read
      cb = '{8'h28, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h03};
      run_cmd(1'b1, 1'b1, 3'd1); idle(3);
      // R3 R5: PIO disk write, all-ones fields
      cb = '{8'h2A, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF};
      run_cmd(1'b1, 1'b0, 3'd2); idle(2);
      // R3 R6: DMA optical write, all-ones fields
      cb = '{8'h80, 8'h2A, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF};
      run_cmd(1'b0, 1'b1, 3'd3); idle(2);
      // R7 R9: capacity on target 4
      cb = '{8'h25, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h55, 8'h66};
      run_cmd(1'b1, 1'b1, 3'd4); idle(2);
      // R7 R9: unsupported opcode on target 5
      cb = '{8'h00, 8'h12, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h55, 8'h66};
      run_cmd(1'b0, 1'b1, 3'd5); idle(2);
      // R11: back to back, settings change at each boundary, one-byte command last
      cb = '{8'h00, 8'h28, 8'h00, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h00, 8'h01, 8'h02};
      run_cmd(1'b0, 1'b1, 3'd0);
      cb = '{8'h2A, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 8'h00, 8'h07};
      run_cmd(1'b1, 1'b0, 3'd7);
      cb = '{8'h00};
      run_cmd(1'b0, 1'b0, 3'd1);
      idle(3);
      // R11: truncated PIO read, unreached slots read as zero
      cb = '{8'h28, 8'h00, 8'hAA, 8'hBB};
      run_cmd(1'b1, 1'b0, 3'd0); idle(2);
      // R10 R11: long DMA command, length saturates, extra bytes ignored
      cb = {};
      for (int i = 0; i < 34; i++) cb.push_back((i == 1) ? 8'h28 : 8'(i));
      run_cmd(1'b0, 1'b0, 3'd2); idle(3);

      chk(exp_q.size() == 0, "R2 outstanding results", 64'(exp_q.size()), 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule